// File: doc/BRIEF.md
# CPU Bus Glue with Interrupt Vector Latch

This block sits between an 8-bit microprocessor that uses separate active-low memory-request, I/O-request, opcode-fetch, refresh, read and write strobes and the RAM and I/O devices beside it. It produces an active-low RAM select from the memory-request strobe and one address bit. That select is qualified so that a DRAM refresh cycle never reaches the RAM.

The block also holds one byte of interrupt vector. The processor stores it with an I/O write to a fixed port. When the processor signals an interrupt acknowledge (I/O request and opcode fetch asserted together), the block places the byte on its data-out bus and raises an output enable. The processor uses that byte as the low half of the vector address. The high half comes from the processor's own interrupt register.

The bus is sampled on a clock that lags the main timing clock by a third of a period, so every sampling edge falls inside a level of the horizontal timing signal. All strobes, the decoded address bits and the data byte pass through a two-stage synchronizer before they are decoded. The outputs are registered once after decoding.

Top module: `busGlue`

## Requirements
- R1: Each output reflects bus inputs that were held stable across three rising clock edges: two synchronizer stages, then one output register.
- R2: `ramSelN` is low exactly when `memReqN` = 0, `refreshN` = 1 and address bit 14 = 1.
- R3: While `refreshN` = 0, `ramSelN` stays high, even when `memReqN` = 0 and address bit 14 = 1.
- R4: While `ioReqN` = 0 and `fetchN` = 0, `dataOutEn` is 1 and `dataOut` equals the stored vector byte.
- R5: With address bit 14 = 0, `ramSelN` stays high whatever the other strobes are.
- R6: A cycle with `ioReqN` = 0, `wrN` = 0, `rdN` = 1, `fetchN` = 1 and address bits [7:0] = 0x00 loads `dataIn` into the vector byte. Address bits [15:8] are ignored.
- R7: An I/O write to any port other than 0x00 leaves the vector byte unchanged. This is observed through a later acknowledge.
- R8: Outside an acknowledge, `dataOutEn` is 0 and `dataOut` is 0x00.
- R9: While `rstN` is low, `ramSelN` = 1 and `dataOutEn` = 0. After reset the vector byte reads back as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lagging bus-sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memReqN | input | 1 | Memory request, active low |
| ioReqN | input | 1 | I/O request, active low |
| fetchN | input | 1 | Opcode fetch / acknowledge qualifier, active low |
| refreshN | input | 1 | Refresh cycle, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| addr | input | 16 | Processor address bus |
| dataIn | input | 8 | Processor data bus in |
| ramSelN | output | 1 | RAM chip select, active low |
| dataOut | output | 8 | Vector byte driven during acknowledge |
| dataOutEn | output | 1 | Data-out enable, high only during acknowledge |

## Verification
The bench uses the default parameters: a 16-bit address, select bit 14, an 8-bit port field at 0x00, and two synchronizer stages. At these values the decode inputs are few enough to sweep in full. The bench drives all 64 combinations of memory request, I/O request, fetch, refresh, select bit and write, and checks the select, enable and data outputs for each. It then writes to all 256 port numbers, each time with a different upper address byte, and follows every write with an acknowledge. The vector byte becomes visible only through those acknowledges, so every write that should be ignored is checked as well.

// File: rtl/busGluePkg.sv
package busGluePkg;

  typedef struct packed {
    logic memReqN;
    logic ioReqN;
    logic fetchN;
    logic refreshN;
    logic rdN;
    logic wrN;
  } busStrobes_t;

  localparam int STROBE_W = $bits(busStrobes_t);

  typedef struct packed {
    logic selRam;
    logic loadVec;
    logic driveVec;
  } ctrlStrobes_t;

endpackage

// File: rtl/busGlueSync.sv
module busGlueSync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[0] <= RST_VAL;
          else       pipe[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[s] <= RST_VAL;
          else       pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/busGlueCtrl.sv
module busGlueCtrl
  import busGluePkg::*;
#(
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] VEC_PORT = '0
) (
  input  busStrobes_t        syncStr,
  input  logic               selBit,
  input  logic [PORT_W-1:0]  portAddr,
  output ctrlStrobes_t       ctl
);
  logic memCycle;
  logic ackCycle;
  logic ioWrite;

  always_comb begin
    memCycle = !syncStr.memReqN && syncStr.refreshN;
    ackCycle = !syncStr.ioReqN && !syncStr.fetchN;
    ioWrite  = !syncStr.ioReqN && syncStr.fetchN && !syncStr.wrN && syncStr.rdN;

    ctl.selRam   = memCycle && selBit;
    ctl.driveVec = ackCycle;
    ctl.loadVec  = ioWrite && (portAddr == VEC_PORT);
  end
endmodule

// File: rtl/busGlueData.sv
module busGlueData
  import busGluePkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctl,
  input  logic [DATA_W-1:0] syncData,
  output logic              ramSelN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);
  logic [DATA_W-1:0] vecReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecReg    <= '0;
      ramSelN   <= 1'b1;
      dataOutEn <= 1'b0;
      dataOut   <= '0;
    end else begin
      if (ctl.loadVec) vecReg <= syncData;
      ramSelN   <= !ctl.selRam;
      dataOutEn <= ctl.driveVec;
      dataOut   <= ctl.driveVec ? vecReg : '0;
    end
  end
endmodule

// File: rtl/busGlue.sv
module busGlue
  import busGluePkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SEL_BIT = 14,
  parameter int PORT_W = 8,
  parameter logic [PORT_W-1:0] VEC_PORT = '0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memReqN,
  input  logic              ioReqN,
  input  logic              fetchN,
  input  logic              refreshN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic              ramSelN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);
  localparam int SYNC_W = STROBE_W + 1 + PORT_W + DATA_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {{STROBE_W{1'b1}}, {(SYNC_W-STROBE_W){1'b0}}};

  busStrobes_t       rawStr;
  busStrobes_t       syncStr;
  logic              syncSel;
  logic [PORT_W-1:0] syncPort;
  logic [DATA_W-1:0] syncData;
  logic [SYNC_W-1:0] syncIn;
  logic [SYNC_W-1:0] syncOut;
  ctrlStrobes_t      ctl;

  always_comb begin
    rawStr.memReqN  = memReqN;
    rawStr.ioReqN   = ioReqN;
    rawStr.fetchN   = fetchN;
    rawStr.refreshN = refreshN;
    rawStr.rdN      = rdN;
    rawStr.wrN      = wrN;
  end

  assign syncIn = {rawStr, addr[SEL_BIT], addr[PORT_W-1:0], dataIn};
  assign {syncStr, syncSel, syncPort, syncData} = syncOut;

  busGlueSync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) uSync (
    .clk(clk), .rstN(rstN), .din(syncIn), .dout(syncOut)
  );

  busGlueCtrl #(.PORT_W(PORT_W), .VEC_PORT(VEC_PORT)) uCtrl (
    .syncStr(syncStr), .selBit(syncSel), .portAddr(syncPort), .ctl(ctl)
  );

  busGlueData #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .syncData(syncData),
    .ramSelN(ramSelN), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );
endmodule

// File: rtl/busGlueChecker.sv
module busGlueChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReqN,
  input logic              ioReqN,
  input logic              fetchN,
  input logic              refreshN,
  input logic              selBit,
  input logic              ramSelN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOutEn
);
  logic [1:0] warm;
  logic       ready;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          warm <= '0;
    else if (!(&warm))  warm <= warm + 2'd1;
  end
  assign ready = &warm;

  // R2: a select only follows a non-refresh memory request with the select bit set
  p_sel_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    ready && !ramSelN |-> $past(!memReqN && refreshN && selBit, 3));

  // R3: a refresh cycle never produces a select
  p_no_refresh_sel_r3: assert property (@(posedge clk) disable iff (!rstN)
    ready && $past(!refreshN, 3) |-> ramSelN);

  // R5: select bit low never produces a select
  p_low_bit_r5: assert property (@(posedge clk) disable iff (!rstN)
    ready && $past(!selBit, 3) |-> ramSelN);

  // R4: enable follows an acknowledge
  p_ack_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    ready && $past(!ioReqN && !fetchN, 3) |-> dataOutEn);

  // R8: enable only for an acknowledge, bus quiet otherwise
  p_enable_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    ready && dataOutEn |-> $past(!ioReqN && !fetchN, 3));

  p_quiet_bus_r8: assert property (@(posedge clk) disable iff (!rstN)
    !dataOutEn |-> dataOut == '0);

  // R9: outputs idle during reset
  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_idle_r9: assert (ramSelN && !dataOutEn);
    end
  end
endmodule

bind busGlue busGlueChecker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .memReqN(memReqN), .ioReqN(ioReqN),
  .fetchN(fetchN), .refreshN(refreshN), .selBit(addr[SEL_BIT]),
  .ramSelN(ramSelN), .dataOut(dataOut), .dataOutEn(dataOutEn)
);

// File: tb/busGlue_test.sv
module busGlue_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memReqN = 1'b1, ioReqN = 1'b1, fetchN = 1'b1;
  logic        refreshN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic        ramSelN;
  logic [7:0]  dataOut;
  logic        dataOutEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  busGlue uut (
    .clk(clk), .rstN(rstN), .memReqN(memReqN), .ioReqN(ioReqN),
    .fetchN(fetchN), .refreshN(refreshN), .rdN(rdN), .wrN(wrN),
    .addr(addr), .dataIn(dataIn), .ramSelN(ramSelN),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic mq, input logic iq, input logic m1, input logic rf,
                       input logic rd, input logic wr, input logic [15:0] a, input logic [7:0] d);
    memReqN = mq; ioReqN = iq; fetchN = m1; refreshN = rf;
    rdN = rd; wrN = wr; addr = a; dataIn = d;
    // R1: three rising edges from a held input to the output
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000, 8'h00);
  endtask

  task automatic readVec(input logic [7:0] exp, input string req);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0000, 8'h00);
    check(req, {15'b0, dataOutEn}, 16'h1);
    check(req, {8'h00, dataOut}, {8'h00, exp});
    idle();
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] vec;
    repeat (3) @(negedge clk);
    check("R9 reset sel", {15'b0, ramSelN}, 16'h1);
    check("R9 reset en", {15'b0, dataOutEn}, 16'h0);
    check("R9 reset data", {8'h0, dataOut}, 16'h0);
    rstN = 1'b1;
    idle();
    readVec(8'h00, "R9 vector after reset");

    vec = 8'h00;
    // Full sweep of decode inputs; writes go to port 0x81 so the vector stays put
    for (int i = 0; i < 64; i++) begin
      logic mq, iq, m1, rf, bit14, wr, expSel, expEn;
      {mq, iq, m1, rf, bit14, wr} = i[5:0];
      drive(mq, iq, m1, rf, 1'b1, wr, {1'b0, bit14, 6'h05, 8'h81}, 8'h3C);
      expSel = !(!mq && rf && bit14);
      expEn  = !iq && !m1;
      if (!rf)       check("R3 refresh blocks sel", {15'b0, ramSelN}, {15'b0, expSel});
      else if (!bit14) check("R5 low bit blocks sel", {15'b0, ramSelN}, {15'b0, expSel});
      else           check("R2 sel decode", {15'b0, ramSelN}, {15'b0, expSel});
      if (expEn) begin
        check("R4 ack enable", {15'b0, dataOutEn}, 16'h1);
        check("R4 ack data", {8'h0, dataOut}, {8'h0, vec});
      end else begin
        check("R8 no enable", {15'b0, dataOutEn}, 16'h0);
        check("R8 quiet data", {8'h0, dataOut}, 16'h0);
      end
      idle();
    end

    // Every port number, each followed by an acknowledge read
    for (int p = 0; p < 256; p++) begin
      logic [7:0] d;
      d = p[7:0] ^ 8'h5A;
      drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, {~p[7:0], p[7:0]}, d);
      idle();
      if (p == 0) begin
        vec = d;
        readVec(vec, "R6 port write loads");
      end else begin
        readVec(vec, "R7 other port ignored");
      end
    end

    // A read of the vector port does not load
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'hFF00, 8'hC3);
    idle();
    readVec(vec, "R6 io read ignored");

    // A write with upper address bits set still loads
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'hA700, 8'h96);
    idle();
    readVec(8'h96, "R6 upper bits ignored");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule